// File: doc/BRIEF.md
# Programmable Read-Only Memory Mode Controller

This block is a synthesizable model of a byte-wide electrically erasable read-only memory together with its control logic. Active-low chip-enable, output-enable and program-strobe pins, a two-bit supply-level code and a flag for the high-voltage line on the ninth address pin are decoded into one operating mode. The modes are read, output disable, standby, program, program verify, erase, erase verify and inhibit. The data bus is split into an input byte, an output byte and an output-enable, so the surrounding logic can build a three-state pad from them.

A program cycle can only clear bits: the stored byte becomes the old byte ANDed with the input byte. A chip erase is the only way back to ones, and it sets every location to all ones at once. Both writes need the matching high-voltage mode. A write takes effect when the program strobe rises. The strobe is brought into the system clock through a synchronizer and an edge detector. Analog levels and access-time delays are not modelled.

Top module: `eprom_mode_ctl`

## Requirements
- R1: With `ce_n` high and `vpp_lvl` = 00 (normal supply), `data_oe` is 0 for every combination of `oe_n` and `pgm_n`.
- R2: With `ce_n` low, `oe_n` low and `vpp_lvl` = 00, `data_oe` is 1 and `data_out` equals the byte stored at `addr`, in the same cycle.
- R3: With `ce_n` low, `oe_n` high and `vpp_lvl` = 00, `data_oe` is 0.
- R4: With `vpp_lvl` = 01 (program level), `ce_n` low and `oe_n` high, a low pulse on `pgm_n` writes at `addr`. The write is complete by the third rising `clk` edge after `pgm_n` returns high.
- R5: A program write stores the old byte ANDed with `data_in`, so no bit ever changes from 0 to 1.
- R6: With `vpp_lvl` = 10 (erase level), `a9_hv` = 1, `addr[0]` = 0, `ce_n` low and `oe_n` high, a `pgm_n` pulse sets every location to FF hex.
- R7: An erase pulse with `a9_hv` = 0, or with `addr[0]` = 1, changes no location.
- R8: With `vpp_lvl` = 01 or 10, `ce_n` low, `oe_n` low and `pgm_n` high, `data_oe` is 1 and `data_out` shows the stored byte. If `pgm_n` is low under the same conditions, `data_oe` is 0.
- R9: With `ce_n` high and `vpp_lvl` = 01 or 10, the block is inhibited: `data_oe` is 0 and a `pgm_n` pulse writes nothing.
- R10: With `vpp_lvl` = 11 (undefined), `data_oe` is 0 and a `pgm_n` pulse writes nothing.
- R11: With `vpp_lvl` = 00, a `pgm_n` pulse writes nothing.
- R12: After reset every location reads FF hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; fills the array with ones |
| addr | input | ADDR_W | Byte address; bit 0 also qualifies erase |
| data_in | input | DATA_W | Byte driven onto the pins by the programmer |
| data_out | output | DATA_W | Stored byte at `addr` while driving, else zero |
| data_oe | output | 1 | High when the block drives the data pins |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low; the write happens on its rising edge |
| vpp_lvl | input | 2 | Supply level: 00 normal, 01 program, 10 erase, 11 undefined |
| a9_hv | input | 1 | High-voltage flag on the ninth address line |

## Verification
The bench builds the block with a depth of 16 bytes and a 4-bit address. At that size every location can be programmed, read back in both read and verify modes, and reprogrammed with a second pattern, so the AND merge is seen on the whole array. The bench sweeps all control-pin combinations in standby, and it sweeps the whole array after each erase and after each blocked write attempt.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  localparam logic [1:0] VPP_NORM  = 2'b00;
  localparam logic [1:0] VPP_PROG  = 2'b01;
  localparam logic [1:0] VPP_ERASE = 2'b10;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_READ,
    MD_ODIS,
    MD_PROG,
    MD_PVER,
    MD_ERASE,
    MD_EVER,
    MD_INHIBIT
  } mode_e;

  // Chip enable dominates; the supply code then picks the family of modes.
  function automatic mode_e decode_mode(input logic ce_n, input logic oe_n,
                                        input logic pgm_n, input logic [1:0] vpp,
                                        input logic a9_hv, input logic a0);
    mode_e m;
    if (ce_n) begin
      m = (vpp == VPP_PROG || vpp == VPP_ERASE) ? MD_INHIBIT : MD_STANDBY;
    end else begin
      case (vpp)
        VPP_NORM:  m = oe_n ? MD_ODIS : MD_READ;
        VPP_PROG:  m = oe_n ? MD_PROG : (pgm_n ? MD_PVER : MD_ODIS);
        VPP_ERASE: begin
          if (oe_n) m = (a9_hv && !a0) ? MD_ERASE : MD_ODIS;
          else      m = pgm_n ? MD_EVER : MD_ODIS;
        end
        default:   m = MD_ODIS;
      endcase
    end
    return m;
  endfunction

  function automatic logic mode_drives(input mode_e m);
    return (m == MD_READ) || (m == MD_PVER) || (m == MD_EVER);
  endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       pgm_n,
  input  logic [1:0] vpp_lvl,
  input  logic       a9_hv,
  input  logic       a0,
  output mode_e      mode,
  output logic       drive_en,
  output logic       prog_ok,
  output logic       erase_ok
);

  always_comb begin
    mode     = decode_mode(ce_n, oe_n, pgm_n, vpp_lvl, a9_hv, a0);
    drive_en = mode_drives(mode);
    prog_ok  = (mode == MD_PROG);
    erase_ok = (mode == MD_ERASE);
  end

  // R8: the bus is only driven with both enables low
  p_drive_needs_enables_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (!ce_n && !oe_n));

  // R7: erase mode needs the high-voltage line and an even address
  p_erase_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_ok |-> (a9_hv && !a0 && vpp_lvl == VPP_ERASE));

endmodule

// File: rtl/eprom_strobe_sync.sv
module eprom_strobe_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_n,
  output logic pgm_rise
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pgm_n};
      hist_q <= sync_q[LAST];
    end
  end

  assign pgm_rise = sync_q[LAST] && !hist_q;

  // R4: one strobe edge yields exactly one write event
  p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_rise |=> !pgm_rise);

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_we,
  input  logic              erase_we,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells [DEPTH];

  // A program cell can only be pulled from 1 to 0.
  function automatic logic [DATA_W-1:0] merge_prog(input logic [DATA_W-1:0] old_b,
                                                   input logic [DATA_W-1:0] new_b);
    return old_b & new_b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (erase_we) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (prog_we) begin
      cells[addr] <= merge_prog(cells[addr], wr_data);
    end
  end

  assign rd_data = cells[addr];

  // R6: after an erase the addressed byte is all ones
  p_erase_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |=> (rd_data == '1));

  // R5: a program write never sets a bit
  p_prog_clears_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> (($past(addr) != addr) || ((rd_data & ~$past(rd_data)) == '0)));

endmodule

// File: rtl/eprom_mode_ctl.sv
module eprom_mode_ctl
  import eprom_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic [1:0]        vpp_lvl,
  input  logic              a9_hv
);

  mode_e             mode;
  logic              drive_en;
  logic              prog_ok;
  logic              erase_ok;
  logic              pgm_rise;
  logic              prog_we;
  logic              erase_we;
  logic [DATA_W-1:0] rd_data;

  eprom_mode_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .pgm_n    (pgm_n),
    .vpp_lvl  (vpp_lvl),
    .a9_hv    (a9_hv),
    .a0       (addr[0]),
    .mode     (mode),
    .drive_en (drive_en),
    .prog_ok  (prog_ok),
    .erase_ok (erase_ok)
  );

  eprom_strobe_sync #(.SYNC_STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pgm_n    (pgm_n),
    .pgm_rise (pgm_rise)
  );

  assign prog_we  = pgm_rise && prog_ok;
  assign erase_we = pgm_rise && erase_ok;

  eprom_cell_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_data  (data_in),
    .prog_we  (prog_we),
    .erase_we (erase_we),
    .rd_data  (rd_data)
  );

  assign data_oe  = drive_en;
  assign data_out = drive_en ? rd_data : '0;

  // R1: chip enable high keeps the bus released
  p_standby_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !data_oe);

  // R9: no write of any kind while chip enable is high
  p_inhibit_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !(prog_we || erase_we));

  // R10: undefined supply code neither drives nor writes
  p_undef_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_lvl == 2'b11) |-> (!data_oe && !prog_we && !erase_we));

  // R11: normal supply never writes
  p_normal_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_lvl == VPP_NORM) |-> !(prog_we || erase_we));

endmodule

// File: tb/eprom_mode_ctl_tb.sv
module eprom_mode_ctl_tb;

  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data_in = 8'hFF;
  logic [7:0]    data_out;
  logic          data_oe;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, a9_hv = 1'b0;
  logic [1:0]    vpp_lvl = 2'b00;

  int errors = 0;
  int checks = 0;
  logic [7:0] expv [DEPTH];

  always #2.5 clk = ~clk;

  eprom_mode_ctl #(.DEPTH(DEPTH), .DATA_W(8), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .vpp_lvl(vpp_lvl), .a9_hv(a9_hv)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setpins(input logic c, input logic o, input logic p, input logic [1:0] v);
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp_lvl = v;
    #1;
  endtask

  // Strobe low for three cycles, then wait past the synchronizer.
  task automatic pulse();
    @(negedge clk); pgm_n = 1'b0;
    repeat (3) @(negedge clk);
    pgm_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Sweep the array in verify or read mode against the model.
  task automatic sweep(input string req, input logic [1:0] v);
    setpins(1'b0, 1'b0, 1'b1, v);
    for (int a = 0; a < DEPTH; a++) begin
      addr = a[AW-1:0];
      #1;
      check(req, {data_oe, data_out}, {1'b1, expv[a]});
    end
  endtask

  function automatic logic [7:0] pat_a(input int a);
    return 8'((a * 37 + 5) ^ (a << 4));
  endfunction

  function automatic logic [7:0] pat_b(input int a);
    return 8'(~(a * 11) | 8'h21);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) expv[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 and R2: reset contents through read mode
    sweep("R12 reset ones", 2'b00);

    // R1: standby, every oe_n / pgm_n combination
    for (int k = 0; k < 4; k++) begin
      setpins(1'b1, k[0], k[1], 2'b00);
      check("R1 standby", {8'h00, data_oe}, 9'h000);
    end

    // R3: output disable
    setpins(1'b0, 1'b1, 1'b1, 2'b00);
    check("R3 output disable", {8'h00, data_oe}, 9'h000);

    // R4: program each location with a first pattern
    setpins(1'b0, 1'b1, 1'b1, 2'b01);
    for (int a = 0; a < DEPTH; a++) begin
      addr = a[AW-1:0]; data_in = pat_a(a);
      pulse();
      expv[a] = expv[a] & pat_a(a);
    end
    sweep("R4 program verify", 2'b01);
    sweep("R2 read after program", 2'b00);

    // R5: second pattern is ANDed in
    setpins(1'b0, 1'b1, 1'b1, 2'b01);
    for (int a = 0; a < DEPTH; a++) begin
      addr = a[AW-1:0]; data_in = pat_b(a);
      pulse();
      expv[a] = expv[a] & pat_b(a);
    end
    sweep("R5 and merge", 2'b01);

    // R8: strobe low during verify releases the bus
    addr = 4'd3;
    setpins(1'b0, 1'b0, 1'b0, 2'b01);
    check("R8 verify strobe low", {8'h00, data_oe}, 9'h000);
    setpins(1'b0, 1'b0, 1'b1, 2'b01);

    // R11: strobe under normal supply, output disabled
    data_in = 8'h00; addr = 4'd5;
    setpins(1'b0, 1'b1, 1'b1, 2'b00);
    pulse();
    sweep("R11 no write at normal supply", 2'b00);

    // R9: inhibit under program and erase levels
    data_in = 8'h00; addr = 4'd6;
    setpins(1'b1, 1'b1, 1'b1, 2'b01);
    check("R9 inhibit hiz", {8'h00, data_oe}, 9'h000);
    pulse();
    addr = 4'd0; a9_hv = 1'b1;
    setpins(1'b1, 1'b1, 1'b1, 2'b10);
    check("R9 inhibit hiz erase", {8'h00, data_oe}, 9'h000);
    pulse();
    a9_hv = 1'b0;
    sweep("R9 inhibit no write", 2'b01);

    // R10: undefined supply code
    setpins(1'b0, 1'b0, 1'b1, 2'b11);
    check("R10 undefined hiz", {8'h00, data_oe}, 9'h000);
    addr = 4'd7; data_in = 8'h00;
    setpins(1'b0, 1'b1, 1'b1, 2'b11);
    pulse();
    sweep("R10 undefined no write", 2'b00);

    // R7: erase blocked without the high-voltage flag or with odd address
    addr = 4'd0; a9_hv = 1'b0;
    setpins(1'b0, 1'b1, 1'b1, 2'b10);
    pulse();
    sweep("R7 erase needs a9_hv", 2'b10);
    addr = 4'd1; a9_hv = 1'b1;
    setpins(1'b0, 1'b1, 1'b1, 2'b10);
    pulse();
    sweep("R7 erase needs even address", 2'b10);

    // R6: real erase, checked through erase verify and read
    addr = 4'd2; a9_hv = 1'b1;
    setpins(1'b0, 1'b1, 1'b1, 2'b10);
    pulse();
    a9_hv = 1'b0;
    for (int a = 0; a < DEPTH; a++) expv[a] = 8'hFF;
    sweep("R6 erase verify", 2'b10);
    sweep("R6 read after erase", 2'b00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule